// File: doc/BRIEF.md
# Memory-Mapped Dual GPIO Subsystem

This block is the I/O side of a small 8-bit processor with a 256-location address space. On every bus cycle it sorts the address into one of three targets: external RAM, GPIO port A or GPIO port B. The two ports share the top four addresses. Addresses 0x00 to 0xFB go to RAM. Addresses 0xFC and 0xFD go to port A. Addresses 0xFE and 0xFF go to port B. Each port has a set of eight input pins and an 8-bit output register that drives its eight output pins.

On a read, the block steers one source onto the processor's data-in bus: RAM data, port A read data or port B read data. For a port read, address bit 0 picks the source. An even address returns the live input pins. An odd address returns the output register. On a write, a port always loads its output register, whatever the value of bit 0. The RAM write enable reaches RAM only for addresses in the RAM range, so a port write never changes memory.

Top module: `mmio_gpio_sub`

## Requirements
- R1: `ram_en` is 1 for every address from 0x00 to 0xFB and 0 for 0xFC to 0xFF. The GPIO region is the set of addresses whose bits 7 down to 2 are all 1.
- R2: Inside the GPIO region, address bit 1 picks the port: 0 selects port A (0xFC, 0xFD) and 1 selects port B (0xFE, 0xFF). Exactly one of the three targets is selected on every cycle.
- R3: A read at the even address of a port (0xFC for A, 0xFE for B) returns that port's current input pins on `rdata`.
- R4: A read at the odd address of a port (0xFD for A, 0xFF for B) returns that port's output register on `rdata`.
- R5: When `wr_en` is 1 at an address of a port, the port's output register loads `wdata` at the next rising clock edge, whether address bit 0 is 0 or 1. The output pins show the new value after that edge.
- R6: An output register keeps its value on any cycle without a write to its own port. This covers writes to RAM addresses, writes to the other port, and cycles with `wr_en` at 0.
- R7: `ram_we` equals `wr_en` for RAM-range addresses and is 0 for all GPIO addresses.
- R8: While the asynchronous active-low reset `rst_n` is 0, both output registers are 0x00, and they read back as 0x00 after reset is released.
- R9: `rdata` is combinational from `addr`, the pins, the registers and `ram_rdata`. For a RAM address it equals `ram_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Processor address bus |
| wdata | input | 8 | Processor data-out bus |
| wr_en | input | 1 | Processor write strobe |
| rdata | output | 8 | Data-in bus back to the processor |
| ram_rdata | input | 8 | Read data from external RAM |
| ram_en | output | 1 | RAM selected by the decoder |
| ram_we | output | 1 | RAM write enable, gated by the RAM range |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output pins |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output pins |

## Verification
`rdata`, `ram_en` and `ram_we` are combinational, so they are due in the same cycle the address and pins are applied. The bench drives each vector on a falling edge and samples these outputs one nanosecond later, before the next rising edge. A write reaches `pa_out` or `pb_out` one edge later. The bench therefore samples the port outputs one nanosecond after that rising edge, against values expected for after the write. A read of an odd address in the same vector as a write to that port must still return the old register value. Reset is checked asynchronously: the bench samples the outputs while `rst_n` is low, before any clock edge.

// File: rtl/mmio_gpio_pkg.sv
`timescale 1ns/1ps
package mmio_gpio_pkg;

  // Bus target chosen by the address decoder.
  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_PA  = 2'd1,
    TGT_PB  = 2'd2
  } tgt_e;

  // Number of ports carved out of the top of the map (address bit 1 picks).
  localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/mmio_addr_decode.sv
`timescale 1ns/1ps
module mmio_addr_decode
  import mmio_gpio_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0]        addr,
  output tgt_e                 tgt,
  output logic                 sel_ram,
  output logic [NUM_PORTS-1:0] sel_port,
  output logic                 reg_odd
);

  localparam int unsigned HI_BITS = AW - 2;

  logic in_io;

  // GPIO region: every bit above bit 1 set
  assign in_io = &addr[AW-1:AW-HI_BITS];

  always_comb begin
    sel_port = '0;
    sel_ram  = 1'b0;
    tgt      = TGT_RAM;
    if (!in_io) begin
      sel_ram = 1'b1;
    end else if (addr[1]) begin
      sel_port[1] = 1'b1;
      tgt         = TGT_PB;
    end else begin
      sel_port[0] = 1'b1;
      tgt         = TGT_PA;
    end
  end

  assign reg_odd = addr[0];

endmodule

// File: rtl/mmio_gpio_port.sv
`timescale 1ns/1ps
module mmio_gpio_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic          rd_odd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] pin_out
);

  logic [DW-1:0] out_q;
  logic [DW-1:0] out_d;
  logic          out_ce;

  // next-state: write ignores the low address bit
  always_comb begin
    out_ce = sel & wr_en;
    out_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_ce) begin
      out_q <= out_d;
    end
  end

  // read source: odd -> output register, even -> live pins
  always_comb begin
    if (rd_odd) rd_data = out_q;
    else        rd_data = pin_in;
  end

  assign pin_out = out_q;

endmodule

// File: rtl/mmio_read_mux.sv
`timescale 1ns/1ps
module mmio_read_mux
  import mmio_gpio_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  tgt_e          tgt,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] pa_rdata,
  input  logic [DW-1:0] pb_rdata,
  output logic [DW-1:0] rdata
);

  always_comb begin
    unique case (tgt)
      TGT_PA:  rdata = pa_rdata;
      TGT_PB:  rdata = pb_rdata;
      default: rdata = ram_rdata;
    endcase
  end

endmodule

// File: rtl/mmio_gpio_sub.sv
`timescale 1ns/1ps
module mmio_gpio_sub
  import mmio_gpio_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_en,
  output logic          ram_we,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out
);

  tgt_e                 tgt;
  logic                 sel_ram;
  logic [NUM_PORTS-1:0] sel_port;
  logic                 reg_odd;

  logic [DW-1:0] pin_in_v  [NUM_PORTS];
  logic [DW-1:0] pin_out_v [NUM_PORTS];
  logic [DW-1:0] port_rd_v [NUM_PORTS];

  mmio_addr_decode #(.AW(AW)) u_dec (
    .addr     (addr),
    .tgt      (tgt),
    .sel_ram  (sel_ram),
    .sel_port (sel_port),
    .reg_odd  (reg_odd)
  );

  assign pin_in_v[0] = pa_in;
  assign pin_in_v[1] = pb_in;

  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
    mmio_gpio_port #(.DW(DW)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_port[gi]),
      .wr_en   (wr_en),
      .rd_odd  (reg_odd),
      .wdata   (wdata),
      .pin_in  (pin_in_v[gi]),
      .rd_data (port_rd_v[gi]),
      .pin_out (pin_out_v[gi])
    );
  end

  assign pa_out = pin_out_v[0];
  assign pb_out = pin_out_v[1];

  mmio_read_mux #(.DW(DW)) u_mux (
    .tgt       (tgt),
    .ram_rdata (ram_rdata),
    .pa_rdata  (port_rd_v[0]),
    .pb_rdata  (port_rd_v[1]),
    .rdata     (rdata)
  );

  assign ram_en = sel_ram;
  assign ram_we = sel_ram & wr_en;

endmodule

// File: rtl/mmio_gpio_sub_chk.sv
`timescale 1ns/1ps
module mmio_gpio_sub_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          wr_en,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] ram_rdata,
  input logic          ram_en,
  input logic          ram_we,
  input logic [DW-1:0] pa_in,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pb_in,
  input logic [DW-1:0] pb_out,
  input logic [1:0]    sel_port
);

  logic io_hit, hit_a, hit_b;
  assign io_hit = &addr[AW-1:2];
  assign hit_a  = io_hit & ~addr[1];
  assign hit_b  = io_hit &  addr[1];

  // R2: exactly one target per cycle
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_en, sel_port}) == 1);

  // R1: memory enable tracks the RAM range
  a_r1_ram_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> !io_hit);

  // R7: no RAM write from the GPIO region
  a_r7_ram_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> !ram_we);

  // R3: even port A address reads pins
  a_r3_even_reads_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !addr[0]) |-> rdata == pa_in);

  // R4: odd port B address reads output register
  a_r4_odd_reads_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && addr[0]) |-> rdata == pb_out);

  // R5: write to port A shows on pins after the edge
  a_r5_write_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_a) |=> pa_out == $past(wdata));

  // R6: port B holds without its own write
  a_r6_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_b) |=> $stable(pb_out));

  // R9: RAM data forwarded in the same cycle
  a_r9_ram_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> rdata == ram_rdata);

endmodule

bind mmio_gpio_sub mmio_gpio_sub_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wdata     (wdata),
  .wr_en     (wr_en),
  .rdata     (rdata),
  .ram_rdata (ram_rdata),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .pa_in     (pa_in),
  .pa_out    (pa_out),
  .pb_in     (pb_in),
  .pb_out    (pb_out),
  .sel_port  (sel_port)
);

// File: tb/mmio_gpio_sub_tb_top.sv
`timescale 1ns/1ps
module mmio_gpio_sub_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr, wdata, ram_rdata, pa_in, pb_in;
  logic       wr_en;
  logic [7:0] rdata, pa_out, pb_out;
  logic       ram_en, ram_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mmio_gpio_sub dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .ram_rdata(ram_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .pa_in(pa_in), .pa_out(pa_out), .pb_in(pb_in), .pb_out(pb_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // {wr, addr, wdata, pa_in, pb_in, ram_rdata, exp_rdata, exp_pa, exp_pb, exp_ram_en, exp_ram_we}
  localparam int NV = 14;
  localparam logic [66:0] VEC [NV] = '{
    {1'b1,8'hFC,8'hA5,8'h3C,8'hC3,8'h11,8'h3C,8'hA5,8'h00,1'b0,1'b0}, // R5 even write A, R3 read pins
    {1'b1,8'hFF,8'h5A,8'h3C,8'hC3,8'h11,8'h00,8'hA5,8'h5A,1'b0,1'b0}, // R5 odd write B, R4 old value
    {1'b0,8'hFD,8'h00,8'h3C,8'hC3,8'h11,8'hA5,8'hA5,8'h5A,1'b0,1'b0}, // R4 A readback
    {1'b0,8'hFC,8'h00,8'h0F,8'hC3,8'h11,8'h0F,8'hA5,8'h5A,1'b0,1'b0}, // R3 A pins
    {1'b0,8'hFE,8'h00,8'h0F,8'hF0,8'h11,8'hF0,8'hA5,8'h5A,1'b0,1'b0}, // R3 B pins
    {1'b0,8'hFF,8'h00,8'h0F,8'hF0,8'h11,8'h5A,8'hA5,8'h5A,1'b0,1'b0}, // R4 B readback
    {1'b1,8'hFD,8'h77,8'h0F,8'hF0,8'h11,8'hA5,8'h77,8'h5A,1'b0,1'b0}, // R5 odd write A
    {1'b1,8'hFE,8'h99,8'h0F,8'h81,8'h11,8'h81,8'h77,8'h99,1'b0,1'b0}, // R5 even write B
    {1'b1,8'h00,8'hEE,8'h0F,8'h81,8'h42,8'h42,8'h77,8'h99,1'b1,1'b1}, // R6 R7 RAM write
    {1'b1,8'hFB,8'h12,8'h0F,8'h81,8'h24,8'h24,8'h77,8'h99,1'b1,1'b1}, // R1 top RAM address
    {1'b0,8'h7C,8'h00,8'h0F,8'h81,8'h81,8'h81,8'h77,8'h99,1'b1,1'b0}, // R9 RAM read
    {1'b0,8'hFD,8'h00,8'h0F,8'h81,8'h00,8'h77,8'h77,8'h99,1'b0,1'b0}, // R4 A after odd write
    {1'b0,8'hFF,8'h55,8'h0F,8'h81,8'h00,8'h99,8'h77,8'h99,1'b0,1'b0}, // R6 no strobe
    {1'b1,8'hFC,8'h3E,8'hC0,8'h81,8'h00,8'hC0,8'h3E,8'h99,1'b0,1'b0}  // R2 write A leaves B
  };

  task automatic drive_vec(input logic [66:0] v);
    wr_en     = v[66];
    addr      = v[65:58];
    wdata     = v[57:50];
    pa_in     = v[49:42];
    pb_in     = v[41:34];
    ram_rdata = v[33:26];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 8'h00; wdata = 8'h00; wr_en = 1'b0;
    ram_rdata = 8'h00; pa_in = 8'hFF; pb_in = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset pa_out", pa_out, 8'h00);
    chk("R8 reset pb_out", pb_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    addr = 8'hFD; #1;
    chk("R8 readback A after reset", rdata, 8'h00);
    addr = 8'hFF; #1;
    chk("R8 readback B after reset", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_vec(VEC[i]);
      #1;
      chk("R9 rdata", rdata, VEC[i][25:18]);
      chk("R1 ram_en", {7'd0, ram_en}, {7'd0, VEC[i][1]});
      chk("R7 ram_we", {7'd0, ram_we}, {7'd0, VEC[i][0]});
      @(posedge clk);
      #1;
      chk("R5 pa_out", pa_out, VEC[i][17:10]);
      chk("R5 pb_out", pb_out, VEC[i][9:2]);
    end

    // R6: write to port B must not touch port A, and RAM writes touch neither
    @(negedge clk);
    wr_en = 1'b1; addr = 8'hFF; wdata = 8'h6D;
    @(posedge clk); #1;
    chk("R6 A held on B write", pa_out, 8'h3E);
    chk("R2 B loaded at 0xFF", pb_out, 8'h6D);
    @(negedge clk);
    addr = 8'h80; wdata = 8'hFF;
    @(posedge clk); #1;
    chk("R6 A held on RAM write", pa_out, 8'h3E);
    chk("R6 B held on RAM write", pb_out, 8'h6D);

    // R7: strobe at a GPIO address never enables RAM writes
    @(negedge clk);
    addr = 8'hFE; wdata = 8'h01; #1;
    chk("R7 no ram_we in GPIO", {7'd0, ram_we}, 8'h00);
    chk("R1 ram_en low at 0xFE", {7'd0, ram_en}, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;

    // R8: asynchronous reset mid-run, sampled before any edge
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R8 async pa_out", pa_out, 8'h00);
    chk("R8 async pb_out", pb_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule